// File: doc/BRIEF.md
# Program Counter with Internal Return-Address Stack

This block holds the fetch address of a small processor core and keeps the return addresses of subroutine calls in a ring of on-chip address registers instead of in memory. One active counter drives the fetch address. The remaining counters store the return addresses that calls push. In the default build there are four counters in total: one active and three saved. Each address is 12 bits wide. A parameter pair builds the same design with more counters and a wider address, for example nine counters and 14 bits.

Each cycle the core may request an increment, a jump to a target, a call to a target or a return. A call saves the address that follows the current one and moves to the target. A return moves to the most recently saved address. The stack index wraps modulo the number of saved slots. Nesting too deep therefore overwrites the oldest saved address. Returning too often reads whatever slot the wrapped index selects, and no error is raised.

Top module: `pc_call_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the fetch address becomes 0. Every saved slot becomes 0 and the stack index returns to slot 0.
- R2: With only `step_i` high, the fetch address advances by one on the next edge. It wraps from all ones (12'hFFF by default) to 0.
- R3: With `jump_i` high and no call or return, the fetch address becomes `target_i` on the next edge, and the stack is left unchanged.
- R4: With `call_i` high, the fetch address becomes `target_i` on the next edge. The current address plus one, wrapping from all ones to 0, is saved in the slot the stack index selects, and the index then advances by one.
- R5: With `ret_i` high and no call, the stack index steps back by one and the fetch address becomes the content of that slot. Nested calls up to the number of saved slots (3 by default) return in reverse order.
- R6: The stack index wraps modulo the number of saved slots. A call made when all slots are in use overwrites the oldest saved address.
- R7: A return made when no call is outstanding also wraps the stack index, from slot 0 to the last slot. It loads that slot's content, and nothing else happens.
- R8: When several requests are high in the same cycle, exactly one is honoured, in the priority order call, return, jump, increment.
- R9: With no request high, the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Advance to the next address |
| jump_i | input | 1 | Load `target_i` |
| call_i | input | 1 | Save the next address and load `target_i` |
| ret_i | input | 1 | Load the most recently saved address |
| target_i | input | ADDR_W (12) | Destination for a jump or a call |
| fetch_addr_o | output | ADDR_W (12) | Current fetch address |

## Verification
The hardest situations to reach from the ports are the two wrap cases of the stack index. One is a call made with every slot already holding a live return address. The other is a return after the stack is empty. In both, the fetch address only shows the effect several calls or returns later. Directed sequences cover both cases: four nested calls followed by five returns, and returns issued straight after reset. The random phase weights calls and returns heavily, so the index wraps many times in both directions while jumps and increments are interleaved. Targets are drawn at all ones often enough that a call's saved address wraps to 0.

// File: rtl/pcs_pkg.sv
// Shared types for the program counter with internal return stack.
// Assumes: exactly one operation is selected per cycle.
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_INC  = 3'd1,
        OP_JMP  = 3'd2,
        OP_RET  = 3'd3,
        OP_CALL = 3'd4
    } pcs_op_e;

endpackage

// File: rtl/pcs_arbiter.sv
// Request arbiter: reduces the four request lines to one operation.
// Assumes: the priority order is call, return, jump, increment.
module pcs_arbiter
    import pcs_pkg::*;
(
    input  logic    step_i,
    input  logic    jump_i,
    input  logic    call_i,
    input  logic    ret_i,
    output pcs_op_e op_o
);

    // Fixed-priority selection of the single honoured request.
    always_comb begin
        if (call_i)      op_o = OP_CALL;
        else if (ret_i)  op_o = OP_RET;
        else if (jump_i) op_o = OP_JMP;
        else if (step_i) op_o = OP_INC;
        else             op_o = OP_NONE;
    end

endmodule

// File: rtl/pcs_ret_stack.sv
// Ring of saved return addresses, indexed by a wrapping pointer.
// Assumes: push and pop never occur in the same cycle, and SLOTS >= 2.
module pcs_ret_stack #(
    parameter int ADDR_W = 12,
    parameter int SLOTS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_data_i,
    output logic [ADDR_W-1:0] pop_data_o
);

    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  prev_idx;
    logic [PTR_W-1:0]  next_idx;
    logic [ADDR_W-1:0] slot_q [SLOTS];

    // Neighbouring indices with modulo-SLOTS wrap.
    always_comb begin
        prev_idx = (ptr_q == '0)   ? LAST : ptr_q - PTR_W'(1);
        next_idx = (ptr_q == LAST) ? '0   : ptr_q + PTR_W'(1);
    end

    // Stack index: forward on push, back on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= next_idx;
        else if (pop_i)  ptr_q <= prev_idx;
    end

    // One register per saved slot, written when the index selects it.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push_i && ptr_q == PTR_W'(g))
                slot_q[g] <= push_data_i;
        end
    end

    // The most recently pushed entry sits just below the index.
    assign pop_data_o = slot_q[prev_idx];

    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

    p_push_then_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> pop_data_o == $past(push_data_i));

    p_single_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/pcs_active.sv
// Active program counter: loads, advances or holds the fetch address.
// Assumes: op_i comes from the arbiter; ret_addr_i is the stack top.
module pcs_active
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pcs_op_e           op_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] ret_addr_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus1_o
);

    logic [ADDR_W-1:0] pc_q;

    // Sequential successor, wrapping from all ones to zero.
    assign pc_plus1_o = pc_q + ADDR_W'(1);

    // Next fetch address per the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else begin
            case (op_i)
                OP_CALL: pc_q <= target_i;
                OP_RET:  pc_q <= ret_addr_i;
                OP_JMP:  pc_q <= target_i;
                OP_INC:  pc_q <= pc_plus1_o;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o = pc_q;

    p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_INC |=> pc_q == $past(pc_q) + ADDR_W'(1));

    p_jump_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_JMP |=> pc_q == $past(target_i));

    p_ret_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_RET |=> pc_q == $past(ret_addr_i));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_NONE |=> $stable(pc_q));

endmodule

// File: rtl/pc_call_stack.sv
// Program counter with an on-chip ring of return-address registers.
// Assumes: DEPTH counts all counters, active one included (DEPTH >= 3).
module pc_call_stack #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] fetch_addr_o
);

    import pcs_pkg::*;

    localparam int SLOTS = DEPTH - 1;

    pcs_op_e           op;
    logic [ADDR_W-1:0] pc_plus1;
    logic [ADDR_W-1:0] ret_addr;

    pcs_arbiter u_arb (
        .step_i (step_i),
        .jump_i (jump_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .op_o   (op)
    );

    pcs_ret_stack #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (op == OP_CALL),
        .pop_i       (op == OP_RET),
        .push_data_i (pc_plus1),
        .pop_data_o  (ret_addr)
    );

    pcs_active #(.ADDR_W(ADDR_W)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .target_i   (target_i),
        .ret_addr_i (ret_addr),
        .pc_o       (fetch_addr_o),
        .pc_plus1_o (pc_plus1)
    );

    p_call_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        call_i |=> fetch_addr_o == $past(target_i));

    p_call_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> fetch_addr_o == $past(target_i));

endmodule

// File: tb/test_pc_call_stack.sv
`timescale 1ns/1ps
module test_pc_call_stack;

    localparam int AW    = 12;
    localparam int SLOTS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step = 1'b0, jump = 1'b0, call = 1'b0, ret = 1'b0;
    logic [AW-1:0] target = '0;
    logic [AW-1:0] fetch;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_slot [SLOTS];
    int            m_ptr;
    int            m_occ;

    always #2.5 clk = ~clk;

    pc_call_stack i_pc_call_stack (
        .clk (clk), .rst_n (rst_n), .step_i (step), .jump_i (jump),
        .call_i (call), .ret_i (ret), .target_i (target), .fetch_addr_o (fetch)
    );

    function automatic int idx_back(int p);
        return (p == 0) ? SLOTS - 1 : p - 1;
    endfunction

    function automatic int idx_fwd(int p);
        return (p == SLOTS - 1) ? 0 : p + 1;
    endfunction

    task automatic check(string tag, logic [AW-1:0] exp);
        checks++;
        if (fetch !== exp) begin
            errors++;
            $display("FAIL %s: fetch=%h expected=%h", tag, fetch, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_ptr = 0; m_occ = 0;
        for (int i = 0; i < SLOTS; i++) m_slot[i] = '0;
    endtask

    // Apply one request set for one cycle, update the model, compare.
    task automatic op(bit c, bit r, bit j, bit s, logic [AW-1:0] t);
        string tag;
        call = c; ret = r; jump = j; step = s; target = t;
        if (int'(c) + int'(r) + int'(j) + int'(s) > 1) tag = "R8";
        else if (c) tag = (m_occ == SLOTS) ? "R6" : "R4";
        else if (r) tag = (m_occ == 0) ? "R7" : "R5";
        else if (j) tag = "R3";
        else if (s) tag = "R2";
        else tag = "R9";
        @(posedge clk);
        if (c) begin
            m_slot[m_ptr] = m_pc + AW'(1);
            m_ptr = idx_fwd(m_ptr);
            if (m_occ < SLOTS) m_occ++;
            m_pc = t;
        end else if (r) begin
            m_ptr = idx_back(m_ptr);
            if (m_occ > 0) m_occ--;
            m_pc = m_slot[m_ptr];
        end else if (j) m_pc = t;
        else if (s) m_pc = m_pc + AW'(1);
        @(negedge clk);
        check(tag, m_pc);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; call = 0; ret = 0; jump = 0; step = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        model_reset();
        check("R1", '0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: fetch=%h expected=finished", fetch);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        do_reset();
        // R7: returns on an empty stack after reset give zeros
        op(0, 1, 0, 0, '0);
        op(0, 1, 0, 0, '0);
        // R2: increment wrap at all ones
        op(0, 0, 1, 0, 12'hFFF);
        op(0, 0, 0, 1, '0);
        op(0, 0, 0, 1, '0);
        // R9: idle hold
        op(0, 0, 0, 0, 12'h555);
        // R4: call from all ones saves 0
        do_reset();
        op(0, 0, 1, 0, 12'hFFF);
        op(1, 0, 0, 0, 12'h100);
        op(0, 1, 0, 0, '0);
        // R5 and R6: four nested calls then five returns
        do_reset();
        op(0, 0, 1, 0, 12'h010);
        op(1, 0, 0, 0, 12'h200);
        op(1, 0, 0, 0, 12'h300);
        op(1, 0, 0, 0, 12'h400);
        op(1, 0, 0, 0, 12'h500);
        for (int i = 0; i < 5; i++) op(0, 1, 0, 0, '0);
        // R8: all requests at once, then return beats jump and step
        op(1, 1, 1, 1, 12'h0AB);
        op(0, 1, 1, 1, 12'h0CD);
        op(0, 0, 1, 1, 12'h0EF);
        // Random mix weighted toward calls and returns
        for (int n = 0; n < 4000; n++) begin
            bit c, r, j, s;
            logic [AW-1:0] t;
            c = ($urandom % 4) == 0;
            r = ($urandom % 4) == 0;
            j = ($urandom % 6) == 0;
            s = ($urandom % 2) == 0;
            t = (($urandom % 8) == 0) ? 12'hFFF : AW'($urandom);
            op(c, r, j, s, t);
            if (($urandom % 500) == 0) do_reset();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule